// File: doc/BRIEF.md
# FSK Delay-Multiply Discriminator

This block is the first stage of a frequency-shift-keyed demodulator running at 1200 baud. Each time the sample strobe is high it accepts one unipolar 8-bit sample, turns it into a signed 16-bit word and multiplies that word by the word taken half a bit period earlier. A strobe marks each result. The mark and space tones have different phase advances over that half-bit span, so the sign of the product, averaged by the low-pass filter that follows, gives the bit value.

The product is negated. The 32-bit result carries two copies of its sign bit, and the output keeps only one of them, so the emitted word is the 16-bit field just below the top bit. The length of the delay is a parameter derived from the samples-per-bit ratio, which must be even and at least six. The delay line moves only on accepted samples, so gaps in the sample strobe do not change which samples are paired.

Top module: `fsk_delay_discriminator`

## Requirements
- R1: While reset is asserted and after it is released, `disc_valid` is 0 and `disc_word` is 0. The delay line starts cleared, so the first SAMPLES_PER_BIT/2 results use zero as the delayed operand and are 0.
- R2: A raw sample s becomes the signed word whose upper byte is s minus 0x80 and whose lower byte is zero. For example, 0x81 maps to +256 and 0x7F maps to -256, so pairing a current 0x81 with a delayed 0x7F gives `disc_word` = 0x0002.
- R3: The delayed operand is the converted sample accepted exactly SAMPLES_PER_BIT/2 samples before the current one. For example, a current 0x90 against a delayed 0xC0 gives 0xF800.
- R4: `disc_word` equals bits [30:15] of the negated 32-bit signed product of the current and delayed words.
- R5: `disc_valid` is high for exactly one cycle for each accepted sample. It is high two clock edges after the edge that samples `smp_valid` high, and it is never high otherwise.
- R6: Cycles with `smp_valid` low neither advance nor alter the delay line.
- R7: `disc_word` holds its last value in every cycle where `disc_valid` is low.
- R8: Extreme pairs (current/delayed) give these results and never overflow: 0x00/0x00 gives 0x8000, 0x00/0xFF gives 0x7F00, and 0xFF/0xFF gives 0x81FE.
- R9: A mid-scale sample of 0x80 in either operand gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one sample accepted per high cycle |
| smp_raw | input | IN_W | Unipolar sample, 0x80 is zero |
| disc_valid | output | 1 | Result strobe |
| disc_word | output | WORD_W | Signed discriminator term |

## Verification
The bench builds the block with SAMPLES_PER_BIT = 6, the smallest legal ratio. That gives a three-deep delay line, so the start-up zeros, the wrap of the pairing and the lag of exactly half a bit are all reached within a few samples. Directed pairs cover the conversion, the three extreme pairs and the mid-scale zero. A long run of random samples with random gaps in the strobe checks that idle cycles never shift the pairing, and that the output holds its value between strobes.

// File: rtl/fskd_pkg.sv
package fskd_pkg;
  localparam int unsigned RAW_W_DEF  = 8;
  localparam int unsigned TERM_W_DEF = 16;
  localparam int unsigned PIPE_LAT   = 2;
endpackage

// File: rtl/fskd_level_shift.sv
module fskd_level_shift #(
  parameter int unsigned IN_W   = 8,
  parameter int unsigned WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     raw_en,
  input  logic [IN_W-1:0]          raw_smp,
  output logic                     lvl_en,
  output logic signed [WORD_W-1:0] lvl_word
);
  localparam int unsigned PAD_W = WORD_W - IN_W;
  localparam logic [IN_W-1:0] MID_FLIP = {1'b1, {(IN_W-1){1'b0}}};

  logic                     en_d;
  logic signed [WORD_W-1:0] word_d;

  // unipolar to two's complement: flipping the top bit subtracts mid-scale
  always_comb begin
    en_d   = raw_en;
    word_d = lvl_word;
    if (raw_en) begin
      word_d = {raw_smp ^ MID_FLIP, {PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_en   <= 1'b0;
      lvl_word <= '0;
    end else begin
      lvl_en   <= en_d;
      lvl_word <= word_d;
    end
  end
endmodule

// File: rtl/fskd_delay_line.sv
module fskd_delay_line #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic signed [WORD_W-1:0] din,
  output logic signed [WORD_W-1:0] oldest
);
  logic signed [WORD_W-1:0] tap_q [DEPTH];
  logic signed [WORD_W-1:0] tap_d [DEPTH];

  // next-state: shift by one slot when a sample is pushed
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      if (i == 0) begin : g_head
        always_comb tap_d[i] = push ? din : tap_q[i];
      end else begin : g_body
        always_comb tap_d[i] = push ? tap_q[i-1] : tap_q[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q[i] <= '0;
        else        tap_q[i] <= tap_d[i];
      end
    end
  endgenerate

  assign oldest = tap_q[DEPTH-1];

  AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(oldest)); // R6
endmodule

// File: rtl/fskd_product_stage.sv
module fskd_product_stage #(
  parameter int unsigned WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_en,
  input  logic signed [WORD_W-1:0] op_cur,
  input  logic signed [WORD_W-1:0] op_dly,
  output logic                     res_en,
  output logic signed [WORD_W-1:0] res_word
);
  localparam int unsigned PW = 2 * WORD_W;

  logic signed [PW-1:0]     prod;
  logic signed [PW-1:0]     prod_neg;
  logic signed [WORD_W-1:0] field;
  logic                     en_d;
  logic signed [WORD_W-1:0] word_d;

  always_comb begin
    prod     = PW'(op_cur) * PW'(op_dly);
    prod_neg = -prod;
    // drop the duplicated sign bit: keep the field just below the MSB
    field    = prod_neg[PW-2 -: WORD_W];
    en_d     = op_en;
    word_d   = op_en ? field : res_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_en   <= 1'b0;
      res_word <= '0;
    end else begin
      res_en   <= en_d;
      res_word <= word_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    op_en |-> (prod_neg[PW-1] == prod_neg[PW-2])); // R8
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_cur == '0 || op_dly == '0)) |=> (res_word == '0)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(res_word)); // R7
endmodule

// File: rtl/fsk_delay_discriminator.sv
module fsk_delay_discriminator #(
  parameter int unsigned SAMPLES_PER_BIT = 8,
  parameter int unsigned IN_W            = fskd_pkg::RAW_W_DEF,
  parameter int unsigned WORD_W          = fskd_pkg::TERM_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [IN_W-1:0]          smp_raw,
  output logic                     disc_valid,
  output logic signed [WORD_W-1:0] disc_word
);
  localparam int unsigned HALF_BIT = SAMPLES_PER_BIT / 2;

  logic                     lvl_en;
  logic signed [WORD_W-1:0] lvl_word;
  logic signed [WORD_W-1:0] dly_word;

  fskd_level_shift #(.IN_W(IN_W), .WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .raw_en(smp_valid), .raw_smp(smp_raw),
    .lvl_en(lvl_en), .lvl_word(lvl_word));

  fskd_delay_line #(.WORD_W(WORD_W), .DEPTH(HALF_BIT)) u_line (
    .clk(clk), .rst_n(rst_n), .push(lvl_en), .din(lvl_word),
    .oldest(dly_word));

  fskd_product_stage #(.WORD_W(WORD_W)) u_prod (
    .clk(clk), .rst_n(rst_n), .op_en(lvl_en), .op_cur(lvl_word),
    .op_dly(dly_word), .res_en(disc_valid), .res_word(disc_word));

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ##2 disc_valid); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> ##2 !disc_valid); // R5
endmodule

// File: tb/fsk_delay_discriminator_tb.sv
module fsk_delay_discriminator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SPB        = 6;
  localparam int DEPTH      = SPB / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_raw = 8'h80;
  logic        disc_valid;
  logic [15:0] disc_word;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsk_delay_discriminator #(.SAMPLES_PER_BIT(SPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_raw(smp_raw),
    .disc_valid(disc_valid), .disc_word(disc_word));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: queue of past converted samples, two-edge latency
  int    hist[$];
  int    seen = 0;
  bit    s1_v = 0;
  logic [15:0] s1_d = 0;
  string s1_tag = "R4";
  bit    e_v = 0;
  logic [15:0] e_d = 0;
  string e_tag = "R1";

  function automatic int conv(input logic [7:0] s);
    return (int'(s) - 128) * 256;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < DEPTH; i++) hist.push_back(0);
      seen = 0; s1_v = 0; s1_d = 0; e_v = 0; e_d = 0;
    end else begin
      e_v = s1_v;
      if (s1_v) begin e_d = s1_d; e_tag = s1_tag; end
      s1_v = smp_valid;
      if (smp_valid) begin
        int cur, dl;
        longint p;
        cur = conv(smp_raw);
        dl  = hist.pop_front();
        hist.push_back(cur);
        p = -(longint'(cur) * longint'(dl));
        s1_d = 16'(p >>> 15);
        if (seen < DEPTH)                    s1_tag = "R1";
        else if (cur == 0 || dl == 0)        s1_tag = "R9";
        else if ((cur == -32768 || cur == 32512) && (dl == -32768 || dl == 32512)) s1_tag = "R8";
        else                                 s1_tag = "R4";
        seen++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check("R5 valid", {15'd0, disc_valid}, {15'd0, e_v});
      check(e_v ? e_tag : "R7 hold", disc_word, e_d);
    end
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog R5 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic push(input logic [7:0] s);
    @(negedge clk); smp_valid = 1'b1; smp_raw = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_valid = 1'b0; smp_raw = 8'h5A;
    end
  endtask

  // first sample, DEPTH-1 fillers with gaps, then the later sample
  task automatic pair(input logic [7:0] first, input logic [7:0] later, input int gap);
    push(first);
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (gap > 0) idle(gap);
      push(8'h33);
    end
    if (gap > 0) idle(gap);
    push(later);
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {15'd0, disc_valid}, 16'd0);
    check("R1 reset word", disc_word, 16'd0);
    rst_n = 1'b1;
    idle(3);
    check("R1 idle after reset", disc_word, 16'd0);
    // start-up outputs use zero delayed operand
    push(8'hFF); push(8'h00); push(8'h10);
    idle(4);
    check("R1 startup zeros", disc_word, 16'h0000);

    pair(8'h7F, 8'h81, 0);
    check("R2 conversion", disc_word, 16'h0002);
    pair(8'hC0, 8'h90, 0);
    check("R3 half-bit lag", disc_word, 16'hF800);
    pair(8'hC0, 8'h90, 5);
    check("R3/R6 lag with idle gaps", disc_word, 16'hF800);
    pair(8'h00, 8'h00, 0);
    check("R8 0x00/0x00", disc_word, 16'h8000);
    pair(8'hFF, 8'h00, 1);
    check("R8 0x00/0xFF", disc_word, 16'h7F00);
    pair(8'hFF, 8'hFF, 0);
    check("R8 0xFF/0xFF", disc_word, 16'h81FE);
    pair(8'h80, 8'h47, 0);
    check("R9 mid-scale delayed", disc_word, 16'h0000);
    pair(8'hE3, 8'h80, 2);
    check("R9 mid-scale current", disc_word, 16'h0000);

    for (int n = 0; n < 3000; n++) begin
      push(8'($urandom));
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule